// File: doc/BRIEF.md
# Single-Adder Four-Way Vector Summer

This block adds four input streams element by element, producing one 32-bit result per element from the values arriving on streams A, B, C and D. It owns exactly one pipelined adder and reuses it three times per result. The first use forms the partial sum E = A+B, the second forms F = C+D, and the third forms R = E+F. Each result wraps modulo 2^32. Every port is a valid/ready stream, so the block can sit between any producers and consumers that use that handshake.

There is no global controller and no fixed schedule. A passive scheduler looks at three queues every cycle. The pair queue holds (E,F) pairs and always wins. When it is empty, the scheduler alternates between the A+B queue and the C+D queue. Its ping-pong flag is held in a two-state machine with states TURN_AB and TURN_CD. The machine moves TURN_AB to TURN_CD when an A+B pair is issued and TURN_CD to TURN_AB when a C+D pair is issued. When the indicated queue is empty, the machine stays where it is.

Each operand pair carries a one-bit tag, and its sum keeps that tag. Tag 0 means a partial sum, which is fed back. Tag 1 means a final result, which is sent out. Fed-back partial sums go to a pairing machine with two states. HOLD_EMPTY stores the first value and moves to HOLD_FULL. HOLD_FULL combines the next value with the stored one into a final-tagged pair and returns to HOLD_EMPTY. The scheduler also has a selection enum whose values are PICK_NONE, PICK_PAIR, PICK_AB and PICK_CD. The adder latency is a parameter, and correct operation does not depend on it.

Top module: `quad_sum_engine`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with no input offered, y_valid is 0.
- R2: The n-th result accepted on the output equals (A[n]+B[n]+C[n]+D[n]) mod 2^32. Results leave in the same order as the input elements.
- R3: Whenever the pair queue holds an entry and the adder accepts an issue, that issue is a final-tagged pair (tag 1) taken from the pair queue.
- R4: When no pair is waiting, first-level issues strictly alternate, starting with A+B after reset. An empty target queue holds the flag in place. If only A and B are offered, no output appears and exactly QDEPTH+1 A/B elements are taken in: one is issued and QDEPTH are queued.
- R5: Fed-back partial sums are paired in arrival order. The 2k-th and (2k+1)-th partial sums form one final-tagged pair.
- R6: a_ready is high only while a_valid, b_valid and b_ready are all high, so A and B are always consumed together. The same holds for C and D.
- R7: While y_valid is high and y_ready is low, y_valid stays high in the next cycle and y_data does not change.
- R8: With all inputs offered every cycle and y_ready held high, the steady-state output interval averages 3 cycles.
- R9: R2 and R8 hold for ADD_LAT = 1 and for a larger adder latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Stream A element offered |
| a_data | input | DW | Stream A element |
| a_ready | output | 1 | Stream A element taken |
| b_valid | input | 1 | Stream B element offered |
| b_data | input | DW | Stream B element |
| b_ready | output | 1 | Stream B element taken |
| c_valid | input | 1 | Stream C element offered |
| c_data | input | DW | Stream C element |
| c_ready | output | 1 | Stream C element taken |
| d_valid | input | 1 | Stream D element offered |
| d_data | input | DW | Stream D element |
| d_ready | output | 1 | Stream D element taken |
| y_valid | output | 1 | Result available |
| y_data | output | DW | Four-way sum, wrapped to DW bits |
| y_ready | input | 1 | Consumer accepts the result |

## Verification
The assertions check four behaviours on every cycle: the pair queue's priority over first-level pairs, the strict A+B/C+D alternation, joint intake on each input couple, and that a stalled result stays stable. Only the bench scenarios can show the end-to-end behaviour: correct in-order wrapped sums under random gaps and output stalls, and the refusal to progress when only A and B are offered. The same applies to the intake limit of QDEPTH+1 elements, the 3-cycle average interval of a saturated run, and the same results at two adder latencies.

// File: rtl/qs_pkg.sv
package qs_pkg;
    typedef enum logic [1:0] {PICK_NONE, PICK_PAIR, PICK_AB, PICK_CD} pick_e;
    typedef enum logic {TURN_AB, TURN_CD} turn_e;
    typedef enum logic {HOLD_EMPTY, HOLD_FULL} hold_e;
endpackage

// File: rtl/qs_fifo.sv
module qs_fifo #(
    parameter int W     = 65,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign in_ready  = (cnt != CW'(DEPTH));
    assign out_valid = (cnt != '0);
    assign out_data  = mem[rp];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= in_data;
    end
endmodule

// File: rtl/qs_adder.sv
module qs_adder #(
    parameter int DW  = 32,
    parameter int LAT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_x,
    input  logic [DW-1:0] in_y,
    input  logic          in_fin,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_sum,
    output logic          out_fin,
    input  logic          out_ready
);
    logic [LAT-1:0] stg_v;
    logic [LAT-1:0] stg_f;
    logic [DW-1:0]  stg_s [LAT];
    logic           adv;

    assign adv       = !stg_v[LAT-1] || out_ready;
    assign in_ready  = adv;
    assign out_valid = stg_v[LAT-1];
    assign out_sum   = stg_s[LAT-1];
    assign out_fin   = stg_f[LAT-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
        end else if (adv) begin
            stg_v <= {stg_v[LAT-1:0], in_valid} >> 0;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            stg_s[0] <= in_x + in_y;
            stg_f[0] <= in_fin;
            for (int k = 1; k < LAT; k++) begin
                stg_s[k] <= stg_s[k-1];
                stg_f[k] <= stg_f[k-1];
            end
        end
    end
endmodule

// File: rtl/qs_sched.sv
module qs_sched
    import qs_pkg::*;
#(
    parameter int PW = 65
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pr_valid,
    input  logic [PW-1:0] pr_data,
    output logic          pr_pop,
    input  logic          ab_valid,
    input  logic [PW-1:0] ab_data,
    output logic          ab_pop,
    input  logic          cd_valid,
    input  logic [PW-1:0] cd_data,
    output logic          cd_pop,
    output logic          iss_valid,
    output logic [PW-1:0] iss_data,
    input  logic          iss_ready
);
    turn_e turn_q, turn_d;
    pick_e pick;

    always_comb begin
        pick = PICK_NONE;
        if (pr_valid)                             pick = PICK_PAIR;
        else if (turn_q == TURN_AB && ab_valid)   pick = PICK_AB;
        else if (turn_q == TURN_CD && cd_valid)   pick = PICK_CD;
    end

    always_comb begin
        iss_valid = (pick != PICK_NONE);
        pr_pop    = (pick == PICK_PAIR) && iss_ready;
        ab_pop    = (pick == PICK_AB)   && iss_ready;
        cd_pop    = (pick == PICK_CD)   && iss_ready;
        unique case (pick)
            PICK_PAIR: iss_data = pr_data;
            PICK_AB:   iss_data = ab_data;
            PICK_CD:   iss_data = cd_data;
            PICK_NONE: iss_data = '0;
        endcase
    end

    always_comb begin
        unique case (turn_q)
            TURN_AB: turn_d = ab_pop ? TURN_CD : TURN_AB;
            TURN_CD: turn_d = cd_pop ? TURN_AB : TURN_CD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) turn_q <= TURN_AB;
        else        turn_q <= turn_d;
    end
endmodule

// File: rtl/qs_pairer.sv
module qs_pairer
    import qs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    output logic            in_ready,
    output logic            out_valid,
    output logic [2*DW:0]   out_data,
    input  logic            out_ready
);
    hold_e         st_q, st_d;
    logic [DW-1:0] first_q;
    logic          take;

    assign take = in_valid && in_ready;

    always_comb begin
        unique case (st_q)
            HOLD_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                st_d      = take ? HOLD_FULL : HOLD_EMPTY;
            end
            HOLD_FULL: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                st_d      = take ? HOLD_EMPTY : HOLD_FULL;
            end
        endcase
        out_data = {1'b1, first_q, in_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HOLD_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (take && st_q == HOLD_EMPTY) first_q <= in_data;
    end
endmodule

// File: rtl/quad_sum_engine.sv
module quad_sum_engine #(
    parameter int DW      = 32,
    parameter int ADD_LAT = 1,
    parameter int QDEPTH  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    input  logic [DW-1:0] a_data,
    output logic          a_ready,
    input  logic          b_valid,
    input  logic [DW-1:0] b_data,
    output logic          b_ready,
    input  logic          c_valid,
    input  logic [DW-1:0] c_data,
    output logic          c_ready,
    input  logic          d_valid,
    input  logic [DW-1:0] d_data,
    output logic          d_ready,
    output logic          y_valid,
    output logic [DW-1:0] y_data,
    input  logic          y_ready
);
    localparam int PW = 2 * DW + 1;

    logic [3:0]          in_v, in_r;
    logic [3:0][DW-1:0]  in_d;
    logic [1:0]          lq_v, lq_pop, jq_ready;
    logic [1:0][PW-1:0]  lq_d;

    assign in_v = {d_valid, c_valid, b_valid, a_valid};
    assign in_d = {d_data, c_data, b_data, a_data};
    assign a_ready = in_r[0];
    assign b_ready = in_r[1];
    assign c_ready = in_r[2];
    assign d_ready = in_r[3];

    for (genvar g = 0; g < 2; g++) begin : g_join
        logic both_v;
        assign both_v      = in_v[2*g] && in_v[2*g+1];
        assign in_r[2*g]   = both_v && jq_ready[g];
        assign in_r[2*g+1] = both_v && jq_ready[g];
        qs_fifo #(.W(PW), .DEPTH(QDEPTH)) u_lq (
            .clk(clk), .rst_n(rst_n),
            .in_valid(both_v), .in_data({1'b0, in_d[2*g], in_d[2*g+1]}), .in_ready(jq_ready[g]),
            .out_valid(lq_v[g]), .out_data(lq_d[g]), .out_ready(lq_pop[g])
        );
    end

    logic          pr_v, pr_pop, pin_v, pin_r;
    logic [PW-1:0] pr_d, pin_d;
    logic          iss_v, iss_r;
    logic [PW-1:0] iss_d;
    logic          add_ov, add_or, add_of;
    logic [DW-1:0] add_sum;
    logic          bk_in_v, bk_in_r, bk_v, bk_r;
    logic [DW-1:0] bk_d;

    qs_sched #(.PW(PW)) u_sched (
        .clk(clk), .rst_n(rst_n),
        .pr_valid(pr_v), .pr_data(pr_d), .pr_pop(pr_pop),
        .ab_valid(lq_v[0]), .ab_data(lq_d[0]), .ab_pop(lq_pop[0]),
        .cd_valid(lq_v[1]), .cd_data(lq_d[1]), .cd_pop(lq_pop[1]),
        .iss_valid(iss_v), .iss_data(iss_d), .iss_ready(iss_r)
    );

    qs_adder #(.DW(DW), .LAT(ADD_LAT)) u_add (
        .clk(clk), .rst_n(rst_n),
        .in_valid(iss_v), .in_x(iss_d[2*DW-1:DW]), .in_y(iss_d[DW-1:0]),
        .in_fin(iss_d[PW-1]), .in_ready(iss_r),
        .out_valid(add_ov), .out_sum(add_sum), .out_fin(add_of), .out_ready(add_or)
    );

    assign y_valid = add_ov && add_of;
    assign y_data  = add_sum;
    assign bk_in_v = add_ov && !add_of;
    assign add_or  = add_of ? y_ready : bk_in_r;

    qs_fifo #(.W(DW), .DEPTH(QDEPTH)) u_back_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(bk_in_v), .in_data(add_sum), .in_ready(bk_in_r),
        .out_valid(bk_v), .out_data(bk_d), .out_ready(bk_r)
    );

    qs_pairer #(.DW(DW)) u_pair (
        .clk(clk), .rst_n(rst_n),
        .in_valid(bk_v), .in_data(bk_d), .in_ready(bk_r),
        .out_valid(pin_v), .out_data(pin_d), .out_ready(pin_r)
    );

    qs_fifo #(.W(PW), .DEPTH(QDEPTH)) u_pair_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pin_v), .in_data(pin_d), .in_ready(pin_r),
        .out_valid(pr_v), .out_data(pr_d), .out_ready(pr_pop)
    );
endmodule

// File: rtl/quad_sum_engine_chk.sv
module quad_sum_engine_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pr_valid,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic          iss_fin,
    input logic          ab_pop,
    input logic          cd_pop,
    input logic          a_valid,
    input logic          b_valid,
    input logic          a_ready,
    input logic          b_ready,
    input logic          c_valid,
    input logic          d_valid,
    input logic          c_ready,
    input logic          d_ready,
    input logic          y_valid,
    input logic          y_ready,
    input logic [DW-1:0] y_data
);
    logic last_ab;

    always_ff @(posedge clk) begin
        if (!rst_n)      last_ab <= 1'b0;
        else if (ab_pop) last_ab <= 1'b1;
        else if (cd_pop) last_ab <= 1'b0;
    end

    AST_PAIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_valid && iss_ready) |-> (iss_valid && iss_fin && !ab_pop && !cd_pop)); // R3
    AST_AB_AFTER_CD: assert property (@(posedge clk) disable iff (!rst_n)
        ab_pop |-> !last_ab); // R4
    AST_CD_AFTER_AB: assert property (@(posedge clk) disable iff (!rst_n)
        cd_pop |-> last_ab); // R4
    AST_AB_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> (a_valid && b_valid && b_ready)); // R6
    AST_CD_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
        c_ready |-> (c_valid && d_valid && d_ready)); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && !y_ready) |=> (y_valid && $stable(y_data))); // R7
endmodule

bind quad_sum_engine quad_sum_engine_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .pr_valid(pr_v), .iss_valid(iss_v), .iss_ready(iss_r), .iss_fin(iss_d[2*DW]),
    .ab_pop(lq_pop[0]), .cd_pop(lq_pop[1]),
    .a_valid(a_valid), .b_valid(b_valid), .a_ready(a_ready), .b_ready(b_ready),
    .c_valid(c_valid), .d_valid(d_valid), .c_ready(c_ready), .d_ready(d_ready),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data)
);

// File: tb/quad_sum_engine_tb.sv
`timescale 1ns/100ps

module quad_sum_engine_lane #(
    parameter int LAT = 1
) (
    input logic clk
);
    localparam int NV  = 120;
    localparam int NT  = 60;
    localparam int TOT = NV + NT;
    localparam int QD  = 8;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    int   oidx   = 0;
    int   cyc    = 0;
    logic rst_n;
    logic in_v [4];
    logic [31:0] in_d [4];
    logic in_r [4];
    logic y_valid, y_ready;
    logic [31:0] y_data;
    logic [31:0] vec [4][TOT];
    logic [31:0] expv [TOT];
    int   stamp [TOT];
    int   acc_cnt [4];
    bit   en_ab = 0, en_cd = 0, burst = 0, stall_en = 1;

    quad_sum_engine #(.DW(32), .ADD_LAT(LAT), .QDEPTH(QD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(in_v[0]), .a_data(in_d[0]), .a_ready(in_r[0]),
        .b_valid(in_v[1]), .b_data(in_d[1]), .b_ready(in_r[1]),
        .c_valid(in_v[2]), .c_data(in_d[2]), .c_ready(in_r[2]),
        .d_valid(in_v[3]), .d_data(in_d[3]), .d_ready(in_r[3]),
        .y_valid(y_valid), .y_data(y_data), .y_ready(y_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s lat=%0d: actual %0h expected %0h", req, LAT, act, exv);
        end
    endtask

    task automatic drive(input int s);
        bit acc;
        if (s < 2) wait (en_ab); else wait (en_cd);
        @(negedge clk);
        for (int i = 0; i < TOT; i++) begin
            if (i == NV) begin
                wait (burst);
                @(negedge clk);
            end
            if (i < NV) repeat ($urandom_range(0, 2)) @(negedge clk);
            in_v[s] = 1'b1;
            in_d[s] = vec[s][i];
            do begin
                #1;
                acc = in_r[s];
                @(negedge clk);
            end while (!acc);
            acc_cnt[s]++;
            in_v[s] = 1'b0;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial drive(0);
    initial drive(1);
    initial drive(2);
    initial drive(3);

    initial begin
        logic        held_v;
        logic [31:0] held_d;
        held_v = 0;
        held_d = 0;
        y_ready = 0;
        forever begin
            @(negedge clk);
            y_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
            #1;
            if (rst_n && held_v)
                check(y_valid && (y_data == held_d), "R7", y_data, held_d);
            held_v = rst_n && y_valid && !y_ready;
            held_d = y_data;
            if (rst_n && y_valid && y_ready) begin
                if (oidx < TOT) begin
                    check(y_data == expv[oidx], "R2 R5 R9", y_data, expv[oidx]);
                    stamp[oidx] = cyc;
                end else begin
                    check(1'b0, "R2", 32'(oidx), 32'(TOT));
                end
                oidx++;
            end
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            in_v[s] = 0;
            in_d[s] = 0;
            acc_cnt[s] = 0;
        end
        for (int i = 0; i < TOT; i++) begin
            for (int s = 0; s < 4; s++)
                vec[s][i] = (i % 5 == 0) ? (32'hFFFF_FF00 | 32'($urandom_range(0, 255))) : $urandom;
            expv[i] = vec[0][i] + vec[1][i] + vec[2][i] + vec[3][i];
        end
        rst_n = 0;
        repeat (4) @(negedge clk);
        #1 check(y_valid == 1'b0, "R1", {31'd0, y_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1;
        #1 check(y_valid == 1'b0, "R1", {31'd0, y_valid}, 32'd0);

        @(negedge clk);
        in_v[0] = 1'b1;
        in_d[0] = 32'h1234;
        repeat (3) begin
            #1;
            check(in_r[0] == 1'b0, "R6", {31'd0, in_r[0]}, 32'd0);
            check(in_r[1] == 1'b0, "R6", {31'd0, in_r[1]}, 32'd0);
            @(negedge clk);
        end
        in_v[0] = 1'b0;

        en_ab = 1;
        repeat (80) begin
            @(negedge clk);
            #1 check(y_valid == 1'b0, "R4", {31'd0, y_valid}, 32'd0);
        end
        check(acc_cnt[0] == QD + 1, "R4", 32'(acc_cnt[0]), 32'(QD + 1));
        check(acc_cnt[1] == QD + 1, "R4", 32'(acc_cnt[1]), 32'(QD + 1));
        check(acc_cnt[2] == 0, "R6", 32'(acc_cnt[2]), 32'd0);

        en_cd = 1;
        wait (oidx >= NV);
        @(negedge clk);
        stall_en = 0;
        burst = 1;
        wait (oidx >= TOT);
        repeat (20) @(negedge clk);
        check(oidx == TOT, "R2", 32'(oidx), 32'(TOT));
        begin
            int span;
            span = stamp[NV + 50] - stamp[NV + 10];
            check(span >= 116 && span <= 124, "R8 R9", 32'(span), 32'd120);
        end
        done = 1;
    end
endmodule

module quad_sum_engine_tb;
    logic clk = 0;
    always #2.5 clk = ~clk;

    quad_sum_engine_lane #(.LAT(1)) u_lane_fast (.clk(clk));
    quad_sum_engine_lane #(.LAT(4)) u_lane_slow (.clk(clk));

    initial begin
        int extra_fail;
        int ncyc;
        extra_fail = 0;
        ncyc = 0;
        while (!(u_lane_fast.done && u_lane_slow.done) && ncyc < 150000) begin
            @(posedge clk);
            ncyc++;
        end
        if (!(u_lane_fast.done && u_lane_slow.done)) begin
            extra_fail = 1;
            $display("FAIL R2 watchdog: outputs %0d/%0d expected %0d", u_lane_fast.oidx, u_lane_slow.oidx, 180);
        end
        $display("CHECKS %0d ERRORS %0d",
                 u_lane_fast.checks + u_lane_slow.checks + extra_fail,
                 u_lane_fast.errors + u_lane_slow.errors + extra_fail);
        $finish;
    end
endmodule